// File: doc/BRIEF.md
# Accumulator-and-Stack Execution Unit

This unit executes zero-address arithmetic. Every arithmetic instruction takes the accumulator as its left operand and the entry on top of an internal last-in, first-out operand stack as its right operand. It writes the result back into the accumulator and removes that stack entry. Transfer instructions carry a single register index. They copy a register into the accumulator, push a register onto the stack, or pop the stack into a register. The highest index value names the accumulator itself, so the accumulator can be pushed and popped like any other register.

The register file is outside the block. Each instruction arrives with its opcode, its register index and the current contents of that register, under a valid/ready handshake. Pops to a register leave the block through a write-back port. Division is an iterative restoring divider, and it is the only multi-cycle operation.

The unit has two states. In `S_READY` it accepts one instruction per cycle. An accepted divide with a usable divisor takes the transition *start-divide* into `S_DIVIDE`, where `ins_ready` is low. When the quotient is complete, the transition *divide-done* writes the quotient to the accumulator and returns to `S_READY`. Every other instruction takes the transition *single-cycle* and stays in `S_READY`. Misuse of the stack and division by zero each set a sticky flag that stays set until reset.

Top module: `zstack_exec`

## Requirements
- R1: After reset the accumulator is 0, all three flags are 0, `wb_en` is 0 and `ins_ready` is 1.
- R2: ADD (op 1), SUB (op 2) and MUL (op 3) with a non-empty stack set the accumulator to `acc + top`, `acc - top` or `acc * top`, keeping the low 16 bits. They remove the top entry.
- R3: DIV (op 4) with a non-empty stack and a non-zero top removes the top entry and holds `ins_ready` low while it divides. When `ins_ready` rises again, the accumulator holds the unsigned quotient `acc / top`.
- R4: DIV with a zero top removes that entry, leaves the accumulator unchanged and sets `div0_o`. The flag stays set.
- R5: PUSH (op 6) places `ins_rdata` on the stack. With index 7 it pushes the accumulator instead.
- R6: POP (op 7) with index 0..6 removes the top entry and drives it on `wb_data`, with `wb_idx` equal to the index and `wb_en` high, in the cycle after acceptance. POP with index 7 loads the top entry into the accumulator and raises no write-back.
- R7: LOAD (op 5) copies `ins_rdata` into the accumulator. With index 7 the accumulator is unchanged.
- R8: Entries leave the stack in the reverse of the order in which they were pushed.
- R9: A PUSH when the stack already holds 16 entries is ignored and sets the sticky `ovf_o`. The stack contents are unchanged.
- R10: A POP or an arithmetic instruction on an empty stack is ignored: the accumulator is unchanged and no write-back occurs. It sets the sticky `udf_o`.
- R11: NOP (op 0) changes neither the accumulator, the stack nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Unit can accept an instruction |
| ins_op | input | 3 | Opcode |
| ins_idx | input | 3 | Register index; 7 names the accumulator |
| ins_rdata | input | 16 | Current contents of register `ins_idx` |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 3 | Register written back |
| wb_data | output | 16 | Value written back |
| acc_o | output | 16 | Accumulator |
| ovf_o | output | 1 | Sticky stack-overflow flag |
| udf_o | output | 1 | Sticky stack-underflow flag |
| div0_o | output | 1 | Sticky divide-by-zero flag |

## Verification
Two functions can land in the same cycle. The first pair is an accumulator update and a following PUSH of the accumulator: a directed ADD followed at once by PUSH index 7 must push the new sum, not the old accumulator. The second pair is the error detection and the suppression of the write-back it cancels: a POP to a register on an empty stack must raise `udf_o` in the same cycle in which `wb_en` stays low. Random instruction streams from a fixed seed hit both pairs many more times. Each result is judged against a bench model of the stack, the registers and the accumulator.

// File: rtl/zse_pkg.sv
package zse_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4,
        OP_LOAD = 3'd5,
        OP_PUSH = 3'd6,
        OP_POP  = 3'd7
    } zse_op_e;

    typedef enum logic {
        S_READY  = 1'b0,
        S_DIVIDE = 1'b1
    } zse_state_e;
endpackage

// File: rtl/zse_lifo.sv
module zse_lifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] top,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  top_ptr;
    logic [PTR_W-1:0]  wr_ptr;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign top_ptr = PTR_W'(level - CNT_W'(1));
    assign wr_ptr  = PTR_W'(level);
    assign top     = empty ? '0 : mem[top_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (push && !full) begin
            level <= level + CNT_W'(1);
        end else if (pop && !empty) begin
            level <= level - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wr_ptr] <= wdata;
        end
    end
endmodule

// File: rtl/zse_divider.sv
module zse_divider #(
    parameter int DATA_W = 16,
    localparam int STEP_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              done,
    output logic [DATA_W-1:0] quotient
);
    logic [DATA_W-1:0] rem_q;
    logic [DATA_W-1:0] dvs_q;
    logic [STEP_W-1:0] steps_q;
    logic              busy_q;
    logic [DATA_W:0]   shifted;
    logic [DATA_W:0]   diff;
    logic              fits;

    // one restoring step: bring in the next dividend bit, subtract if it fits
    assign shifted = {rem_q, quotient[DATA_W-1]};
    assign diff    = shifted - {1'b0, dvs_q};
    assign fits    = !diff[DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            quotient <= '0;
            steps_q  <= '0;
            busy_q   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q    <= '0;
                dvs_q    <= divisor;
                quotient <= dividend;
                steps_q  <= STEP_W'(DATA_W);
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                rem_q    <= fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
                quotient <= {quotient[DATA_W-2:0], fits};
                steps_q  <= steps_q - STEP_W'(1);
                if (steps_q == STEP_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/zstack_exec.sv
module zstack_exec #(
    parameter int DATA_W    = 16,
    parameter int STK_DEPTH = 16,
    parameter int IDX_W     = 3,
    localparam int CNT_W    = $clog2(STK_DEPTH + 1),
    localparam logic [IDX_W-1:0] ACC_IDX = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [2:0]        ins_op,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic [DATA_W-1:0] ins_rdata,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] acc_o,
    output logic              ovf_o,
    output logic              udf_o,
    output logic              div0_o
);
    import zse_pkg::*;

    zse_state_e        state_q, state_d;
    zse_op_e           op;
    logic              fire;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] acc_d;
    logic              ovf_d, udf_d, div0_d;
    logic              wb_en_d;
    logic [IDX_W-1:0]  wb_idx_d;
    logic [DATA_W-1:0] wb_data_d;
    logic              stk_push, stk_pop;
    logic [DATA_W-1:0] stk_top;
    logic [CNT_W-1:0]  stk_level;
    logic              stk_full, stk_empty;
    logic              div_start, div_done;
    logic [DATA_W-1:0] div_quo;

    assign op        = zse_op_e'(ins_op);
    assign ins_ready = (state_q == S_READY);
    assign fire      = ins_valid && ins_ready;
    assign src_val   = (ins_idx == ACC_IDX) ? acc_o : ins_rdata;

    zse_lifo #(.DATA_W(DATA_W), .DEPTH(STK_DEPTH)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .wdata (src_val),
        .top   (stk_top),
        .level (stk_level),
        .full  (stk_full),
        .empty (stk_empty)
    );

    zse_divider #(.DATA_W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (acc_o),
        .divisor  (stk_top),
        .done     (div_done),
        .quotient (div_quo)
    );

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        acc_d     = acc_o;
        ovf_d     = ovf_o;
        udf_d     = udf_o;
        div0_d    = div0_o;
        wb_en_d   = 1'b0;
        wb_idx_d  = wb_idx;
        wb_data_d = wb_data;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        div_start = 1'b0;
        unique case (state_q)
            S_READY: begin
                if (fire) begin
                    unique case (op)
                        OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                            if (stk_empty) begin
                                udf_d = 1'b1;
                            end else begin
                                stk_pop = 1'b1;
                                if (op == OP_ADD) begin
                                    acc_d = acc_o + stk_top;
                                end else if (op == OP_SUB) begin
                                    acc_d = acc_o - stk_top;
                                end else if (op == OP_MUL) begin
                                    acc_d = acc_o * stk_top;
                                end else if (stk_top == '0) begin
                                    div0_d = 1'b1;
                                end else begin
                                    div_start = 1'b1;
                                    state_d   = S_DIVIDE;
                                end
                            end
                        end
                        OP_LOAD: acc_d = src_val;
                        OP_PUSH: begin
                            if (stk_full) ovf_d = 1'b1;
                            else          stk_push = 1'b1;
                        end
                        OP_POP: begin
                            if (stk_empty) begin
                                udf_d = 1'b1;
                            end else begin
                                stk_pop = 1'b1;
                                if (ins_idx == ACC_IDX) begin
                                    acc_d = stk_top;
                                end else begin
                                    wb_en_d   = 1'b1;
                                    wb_idx_d  = ins_idx;
                                    wb_data_d = stk_top;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_DIVIDE: begin
                if (div_done) begin
                    acc_d   = div_quo;
                    state_d = S_READY;
                end
            end
        endcase
    end

    // state and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_READY;
            acc_o   <= '0;
            ovf_o   <= 1'b0;
            udf_o   <= 1'b0;
            div0_o  <= 1'b0;
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            state_q <= state_d;
            acc_o   <= acc_d;
            ovf_o   <= ovf_d;
            udf_o   <= udf_d;
            div0_o  <= div0_d;
            wb_en   <= wb_en_d;
            wb_idx  <= wb_idx_d;
            wb_data <= wb_data_d;
        end
    end
endmodule

// File: rtl/zse_exec_chk.sv
module zse_exec_chk
    import zse_pkg::*;
#(
    parameter int STK_DEPTH = 16,
    parameter int IDX_W     = 3,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [2:0]        ins_op,
    input logic [IDX_W-1:0]  ins_idx,
    input logic              wb_en,
    input logic [DATA_W-1:0] acc_o,
    input logic              ovf_o,
    input logic              udf_o,
    input logic              div0_o,
    input zse_state_e        state_q,
    input logic [CNT_W-1:0]  stk_level
);
    localparam logic [IDX_W-1:0] ACC_SEL = '1;

    // R3
    divide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_DIVIDE |-> !ins_ready);

    // R6
    wb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(ins_valid && ins_ready && ins_op == OP_POP && ins_idx != ACC_SEL));

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_op == OP_POP && stk_level == '0) |=> !wb_en);

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= CNT_W'(STK_DEPTH));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R10
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udf_o |=> udf_o);

    // R4
    div0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div0_o) |-> acc_o == $past(acc_o));
endmodule

bind zstack_exec zse_exec_chk #(
    .STK_DEPTH (STK_DEPTH),
    .IDX_W     (IDX_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_op    (ins_op),
    .ins_idx   (ins_idx),
    .wb_en     (wb_en),
    .acc_o     (acc_o),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o),
    .div0_o    (div0_o),
    .state_q   (state_q),
    .stk_level (stk_level)
);

// File: tb/test_zstack_exec.sv
module test_zstack_exec;
    localparam logic [2:0] C_NOP = 3'd0, C_ADD = 3'd1, C_SUB = 3'd2, C_MUL = 3'd3,
                           C_DIV = 3'd4, C_LOAD = 3'd5, C_PUSH = 3'd6, C_POP = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [2:0]  ins_op = '0;
    logic [2:0]  ins_idx = '0;
    logic [15:0] ins_rdata = '0;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [15:0] wb_data;
    logic [15:0] acc_o;
    logic        ovf_o, udf_o, div0_o;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] m_reg [8];
    logic [15:0] m_stk [16];
    int          m_cnt = 0;
    logic [15:0] m_acc = '0;
    logic        m_ovf = 1'b0, m_udf = 1'b0, m_div0 = 1'b0;

    always #5 clk = ~clk;

    zstack_exec i_zstack_exec (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_op(ins_op), .ins_idx(ins_idx), .ins_rdata(ins_rdata),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .acc_o(acc_o),
        .ovf_o(ovf_o), .udf_o(udf_o), .div0_o(div0_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_arith(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            C_ADD:   return a + b;
            C_SUB:   return a - b;
            C_MUL:   return a * b;
            default: return a / b;
        endcase
    endfunction

    task automatic run(input logic [2:0] op, input logic [2:0] idx);
        logic [15:0] src;
        logic        e_wb = 1'b0;
        logic [15:0] e_wbd = '0;
        logic        e_busy = 1'b0;
        src = (idx == 3'd7) ? m_acc : m_reg[idx];
        // bench model
        case (op)
            C_ADD, C_SUB, C_MUL, C_DIV: begin
                if (m_cnt == 0) m_udf = 1'b1;
                else begin
                    m_cnt--;
                    if (op == C_DIV && m_stk[m_cnt] == 16'd0) m_div0 = 1'b1;
                    else begin
                        e_busy = (op == C_DIV);
                        m_acc = ref_arith(op, m_acc, m_stk[m_cnt]);
                    end
                end
            end
            C_LOAD: m_acc = src;
            C_PUSH: begin
                if (m_cnt == 16) m_ovf = 1'b1;
                else begin m_stk[m_cnt] = src; m_cnt++; end
            end
            C_POP: begin
                if (m_cnt == 0) m_udf = 1'b1;
                else begin
                    m_cnt--;
                    if (idx == 3'd7) m_acc = m_stk[m_cnt];
                    else begin e_wb = 1'b1; e_wbd = m_stk[m_cnt]; end
                end
            end
            default: ;
        endcase
        while (!ins_ready) @(negedge clk);
        ins_valid = 1'b1; ins_op = op; ins_idx = idx;
        ins_rdata = (idx == 3'd7) ? 16'hdead : m_reg[idx];
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        // R6 / R10: write-back strobe and payload
        chk(wb_en == e_wb, "R6 wb_en", 32'(wb_en), 32'(e_wb));
        if (e_wb) begin
            chk(wb_idx == idx && wb_data == e_wbd, "R6 wb payload R8",
                {13'd0, wb_idx, wb_data}, {13'd0, idx, e_wbd});
            m_reg[idx] = e_wbd;
        end
        if (e_busy) chk(ins_ready == 1'b0, "R3 ready low while dividing", 32'(ins_ready), 0);
        while (!ins_ready) @(negedge clk);
        chk(acc_o == m_acc, "R2 R3 R7 accumulator", 32'(acc_o), 32'(m_acc));
        chk({ovf_o, udf_o, div0_o} == {m_ovf, m_udf, m_div0}, "R4 R9 R10 flags",
            32'({ovf_o, udf_o, div0_o}), 32'({m_ovf, m_udf, m_div0}));
    endtask

    task automatic set_reg(input int i, input logic [15:0] v);
        m_reg[i] = v;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                vectors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_reg[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(acc_o == 16'd0, "R1 acc", 32'(acc_o), 0);
        chk({ovf_o, udf_o, div0_o, wb_en} == 4'b0, "R1 flags", 32'({ovf_o, udf_o, div0_o, wb_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ins_ready == 1'b1, "R1 ready", 32'(ins_ready), 1);

        // R11 NOP, R7 LOAD
        set_reg(1, 16'd40); set_reg(2, 16'd7); set_reg(0, 16'd0);
        run(C_NOP, 3'd1);
        run(C_LOAD, 3'd1);
        run(C_LOAD, 3'd7);
        // R2 accumulator as left operand: 40 - 7 = 33
        run(C_PUSH, 3'd2);
        run(C_SUB, 3'd0);
        // R5 R2 same-cycle hazard: ADD then PUSH acc must push new sum
        run(C_PUSH, 3'd2);
        run(C_ADD, 3'd0);
        run(C_PUSH, 3'd7);
        run(C_POP, 3'd4);
        chk(m_reg[4] == 16'd40, "R5 pushed updated acc", 32'(m_reg[4]), 40);
        // R10 underflow: pop empty and arithmetic on empty
        run(C_POP, 3'd3);
        run(C_MUL, 3'd0);
        // R3 division and R4 division by zero
        run(C_LOAD, 3'd1);
        run(C_PUSH, 3'd2);
        run(C_DIV, 3'd0);
        run(C_PUSH, 3'd0);
        run(C_DIV, 3'd0);
        // R8 LIFO order then R9 overflow
        for (int k = 0; k < 16; k++) begin
            set_reg(5, 16'(k * 3 + 1));
            run(C_PUSH, 3'd5);
        end
        set_reg(6, 16'hbeef);
        run(C_PUSH, 3'd6);
        for (int k = 15; k >= 0; k--) begin
            run(C_POP, 3'd3);
            chk(m_reg[3] == 16'(k * 3 + 1), "R8 R9 pop order", 32'(m_reg[3]), 32'(k * 3 + 1));
        end
        // R6 POP into accumulator
        run(C_PUSH, 3'd6);
        run(C_POP, 3'd7);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [2:0] op;
            logic [2:0] idx;
            r = int'($urandom_range(0, 99));
            idx = 3'($urandom_range(0, 7));
            if (r < 30)      op = C_PUSH;
            else if (r < 48) op = C_POP;
            else if (r < 58) op = C_LOAD;
            else if (r < 95) op = 3'($urandom_range(1, 4));
            else             op = C_NOP;
            if ($urandom_range(0, 9) == 0 && idx != 3'd7) m_reg[idx] = 16'($urandom_range(0, 3));
            run(op, idx);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule